// File: doc/BRIEF.md
# Jitter Sampling Random Bit Decimator

This block turns the phase noise of a jittery clock into random bits. The jittery waveform is never used as a clock. It arrives as data, together with optional copies of itself that are already delayed, and each copy is captured by its own flip-flop on the rising edge of the reference clock. The captured copies are XOR-combined into one sample per reference cycle. A modulo-2 decimator then folds a fixed number of consecutive samples (`DECIM`) into one output bit, so random bits leave at the reference rate divided by `DECIM`. A packer gathers the bits into bytes for a downstream buffer.

The capture path can use one flop per lane or a two-flop synchronizer per lane, selected by `SYNC2`. The ratio parameters are checked during elaboration: the multiplier `MULT` and the divider `DECIM` must satisfy gcd(2·MULT, DECIM) = 1, so that the reference edges spread evenly across the jittery waveform.

The capture stage has two states. CAP_PRIME lasts while the sample pipeline fills after reset and moves to CAP_LIVE after `LAT` edges. CAP_LIVE is then held until the next reset. The decimator moves from DEC_IDLE to DEC_GATHER on the first valid sample of a group, and from DEC_GATHER back to DEC_IDLE on the sample that completes the group, which is also when the bit is emitted. The packer moves from PK_EMPTY to PK_FILL on the first bit of a byte, and from PK_FILL back to PK_EMPTY on the eighth bit.

Top module: `jitter_sampler`

## Requirements
- R1: Each lane of `jit_in` (lane 0 direct, lanes 1..TAPS delayed copies) is captured by its own reference-clock flop, and the per-cycle sample is the XOR of all captured lanes.
- R2: Each output bit is the XOR of `DECIM` consecutive samples, in non-overlapping groups taken in arrival order.
- R3: `bit_valid` is a single-cycle pulse, raised exactly once per `DECIM` consumed samples.
- R4: The capture latency `LAT` is 1 with `SYNC2`=0 and 2 with `SYNC2`=1. Counting the first rising edge with `rst` low as edge 0, the first `bit_valid` follows edge `DECIM+LAT-1`.
- R5: `rst` is synchronous and active high. While it is asserted, all outputs are 0, and it clears the sample counter, the accumulator and any partly filled byte.
- R6: Bits are packed `BYTE_W` (8) at a time, with the first bit of a byte in bit 0. `byte_valid` is a single-cycle pulse in the cycle after the `bit_valid` of the eighth bit.
- R7: Elaboration fails unless gcd(2·MULT, DECIM) = 1 and DECIM ≥ 2.
- R8: `rnd_bit` and `rnd_byte` keep their last value between their valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every flop uses it |
| rst | input | 1 | Synchronous active-high reset |
| jit_in | input | TAPS+1 | Jittery waveform (lane 0) and its delayed copies |
| rnd_bit | output | 1 | Latest decimated random bit |
| bit_valid | output | 1 | One-cycle strobe for a new `rnd_bit` |
| rnd_byte | output | BYTE_W | Latest packed byte, first bit at bit 0 |
| byte_valid | output | 1 | One-cycle strobe for a new `rnd_byte` |

## Verification
The bench builds two instances side by side. The first uses DECIM=7, MULT=12, three lanes and single-flop capture. The second uses DECIM=5, MULT=3, one lane and the two-flop synchronizer. With such short groups, hundreds of bits and dozens of bytes fit into a few hundred cycles, which brings group boundaries, byte boundaries and the first-bit latency of both capture variants within reach many times over. A counting pattern walks all eight lane combinations of the three-lane instance. Pseudo-random and constant patterns follow, and a reset in mid-run discards a partly filled byte.

// File: rtl/jsd_pkg.sv
package jsd_pkg;

    typedef enum logic {CAP_PRIME, CAP_LIVE} cap_state_t;
    typedef enum logic {DEC_IDLE, DEC_GATHER} dec_state_t;
    typedef enum logic {PK_EMPTY, PK_FILL} pk_state_t;

    // Euclid's algorithm, usable in constant expressions
    function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

endpackage

// File: rtl/jsd_capture.sv
module jsd_capture #(
    parameter int unsigned TAPS  = 0,
    parameter bit          SYNC2 = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TAPS:0] lanes_in,
    output logic          sample,
    output logic          sample_vld
);
    import jsd_pkg::*;

    localparam int unsigned LANES = TAPS + 1;
    localparam int unsigned LAT   = SYNC2 ? 2 : 1;
    localparam int unsigned PW    = 2;

    cap_state_t       state_q, state_d;
    logic [PW-1:0]    prime_q;
    logic [LANES-1:0] stage1_q;
    logic [LANES-1:0] lane_q;

    // one capture flop per lane; the jittery input is only ever data
    always_ff @(posedge clk) begin
        if (rst) stage1_q <= '0;
        else     stage1_q <= lanes_in;
    end

    generate
        if (SYNC2) begin : g_sync2
            logic [LANES-1:0] stage2_q;
            always_ff @(posedge clk) begin
                if (rst) stage2_q <= '0;
                else     stage2_q <= stage1_q;
            end
            assign lane_q = stage2_q;
        end else begin : g_sync1
            assign lane_q = stage1_q;
        end
    endgenerate

    assign sample = ^lane_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= CAP_PRIME;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_PRIME: if (prime_q == PW'(LAT - 1)) state_d = CAP_LIVE;
            CAP_LIVE:  state_d = CAP_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                     prime_q <= '0;
        else if (state_q == CAP_PRIME) prime_q <= prime_q + 1'b1;
    end

    assign sample_vld = (state_q == CAP_LIVE);

    AST_VLD_STICKY: assert property (@(posedge clk) disable iff (rst)
        sample_vld |=> sample_vld); // R4

    AST_VLD_CLEARED: assert property (@(posedge clk)
        rst |=> !sample_vld); // R5

endmodule

// File: rtl/jsd_decimator.sv
module jsd_decimator #(
    parameter int unsigned DECIM = 217
) (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic sample_vld,
    output logic bit_out,
    output logic bit_vld
);
    import jsd_pkg::*;

    localparam int unsigned CW = $clog2(DECIM);

    dec_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          acc_q;
    logic          last_smp;

    assign last_smp = sample_vld && (cnt_q == CW'(DECIM - 1));

    always_ff @(posedge clk) begin
        if (rst) state_q <= DEC_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DEC_IDLE:   if (sample_vld) state_d = DEC_GATHER;
            DEC_GATHER: if (last_smp)   state_d = DEC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            acc_q   <= 1'b0;
            bit_out <= 1'b0;
            bit_vld <= 1'b0;
        end else begin
            bit_vld <= 1'b0;
            unique case (state_q)
                DEC_IDLE: begin
                    if (sample_vld) begin
                        acc_q <= sample;
                        cnt_q <= CW'(1);
                    end
                end
                DEC_GATHER: begin
                    if (last_smp) begin
                        bit_out <= acc_q ^ sample;
                        bit_vld <= 1'b1;
                        acc_q   <= 1'b0;
                        cnt_q   <= '0;
                    end else if (sample_vld) begin
                        acc_q <= acc_q ^ sample;
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    AST_BIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        bit_vld |=> !bit_vld); // R3

    AST_BIT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        bit_vld |-> $past(sample_vld)); // R2

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |-> $stable(bit_out)); // R8

    AST_DEC_CLEARED: assert property (@(posedge clk)
        rst |=> (!bit_vld && !bit_out)); // R5

endmodule

// File: rtl/jsd_packer.sv
module jsd_packer #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_vld,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld
);
    import jsd_pkg::*;

    localparam int unsigned IW = $clog2(BYTE_W);

    pk_state_t         state_q, state_d;
    logic [IW-1:0]     idx_q;
    logic [BYTE_W-1:0] buf_q;
    logic              last_bit;

    assign last_bit = bit_vld && (idx_q == IW'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) state_q <= PK_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PK_EMPTY: if (bit_vld)  state_d = PK_FILL;
            PK_FILL:  if (last_bit) state_d = PK_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            buf_q    <= '0;
            byte_out <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            unique case (state_q)
                PK_EMPTY: begin
                    if (bit_vld) begin
                        buf_q[0] <= bit_in;
                        idx_q    <= IW'(1);
                    end
                end
                PK_FILL: begin
                    if (last_bit) begin
                        byte_out <= {bit_in, buf_q[BYTE_W-2:0]};
                        byte_vld <= 1'b1;
                        idx_q    <= '0;
                    end else if (bit_vld) begin
                        buf_q[idx_q] <= bit_in;
                        idx_q        <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld); // R6

    AST_BYTE_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(bit_vld)); // R6

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |-> $stable(byte_out)); // R8

endmodule

// File: rtl/jitter_sampler.sv
module jitter_sampler #(
    parameter int unsigned DECIM  = 217,
    parameter int unsigned MULT   = 43,
    parameter int unsigned TAPS   = 0,
    parameter bit          SYNC2  = 1'b0,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAPS:0]     jit_in,
    output logic              rnd_bit,
    output logic              bit_valid,
    output logic [BYTE_W-1:0] rnd_byte,
    output logic              byte_valid
);
    // R7: reject ratios whose reference edges do not spread evenly
    generate
        if (jsd_pkg::gcd_u(2 * MULT, DECIM) != 1) begin : g_bad_ratio
            $error("jitter_sampler: gcd(2*MULT, DECIM) must equal 1");
        end
        if (DECIM < 2) begin : g_bad_decim
            $error("jitter_sampler: DECIM must be at least 2");
        end
    endgenerate

    logic smp;
    logic smp_vld;

    jsd_capture #(
        .TAPS  (TAPS),
        .SYNC2 (SYNC2)
    ) u_capture (
        .clk        (clk),
        .rst        (rst),
        .lanes_in   (jit_in),
        .sample     (smp),
        .sample_vld (smp_vld)
    );

    jsd_decimator #(
        .DECIM (DECIM)
    ) u_decim (
        .clk        (clk),
        .rst        (rst),
        .sample     (smp),
        .sample_vld (smp_vld),
        .bit_out    (rnd_bit),
        .bit_vld    (bit_valid)
    );

    jsd_packer #(
        .BYTE_W (BYTE_W)
    ) u_pack (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (rnd_bit),
        .bit_vld  (bit_valid),
        .byte_out (rnd_byte),
        .byte_vld (byte_valid)
    );

endmodule

// File: tb/tb_jitter_sampler.sv
module tb_jitter_sampler;

    localparam int unsigned DEC_A = 7;
    localparam int unsigned MUL_A = 12;
    localparam int unsigned DEC_B = 5;
    localparam int unsigned MUL_B = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] jit = 3'b000;

    always #5 clk = ~clk;

    logic       bv_a, bit_a, byv_a, bv_b, bit_b, byv_b;
    logic [7:0] byte_a, byte_b;

    jitter_sampler #(.DECIM(DEC_A), .MULT(MUL_A), .TAPS(2), .SYNC2(1'b0), .BYTE_W(8)) dut (
        .clk(clk), .rst(rst), .jit_in(jit),
        .rnd_bit(bit_a), .bit_valid(bv_a), .rnd_byte(byte_a), .byte_valid(byv_a));

    jitter_sampler #(.DECIM(DEC_B), .MULT(MUL_B), .TAPS(0), .SYNC2(1'b1), .BYTE_W(8)) dut_sync (
        .clk(clk), .rst(rst), .jit_in(jit[0:0]),
        .rnd_bit(bit_b), .bit_valid(bv_b), .rnd_byte(byte_b), .byte_valid(byv_b));

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int unsigned dec [2] = '{DEC_A, DEC_B};
    int unsigned lat [2] = '{1, 2};
    bit          xs [2][512];
    bit          bits [2][128];
    int          nbits [2];
    bit          last_bit [2];
    logic [7:0]  last_byte [2];
    bit          pend [2];
    logic [7:0]  pend_val [2];
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string req, input int i, input int k,
                       input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s inst%0d edge %0d: actual %0h expected %0h", req, i, k, got, exp);
        end
    endtask

    function automatic int unsigned gcd_tb(input int unsigned a, input int unsigned b);
        int unsigned x = a;
        int unsigned y = b;
        while (y != 0) begin
            int unsigned t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < 2; i++) begin
            nbits[i] = 0; last_bit[i] = 1'b0; last_byte[i] = 8'h00; pend[i] = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        jit = 3'b000;
        for (int r = 0; r < 3; r++) begin
            @(negedge clk);
            chk("R5 bit_valid in reset", 0, r, {7'd0, bv_a}, 8'h00);
            chk("R5 rnd_byte in reset", 0, r, byte_a, 8'h00);
            chk("R5 byte_valid in reset", 1, r, {7'd0, byv_b}, 8'h00);
            chk("R5 rnd_bit in reset", 1, r, {7'd0, bit_b}, 8'h00);
        end
        clear_model();
        rst = 1'b0;
    endtask

    task automatic check_edge(input int i, input int k);
        int  cons;
        bit  ebv, ebit, ebyv;
        logic obv, obit, obyv;
        logic [7:0] obyte;
        obv   = (i == 0) ? bv_a   : bv_b;
        obit  = (i == 0) ? bit_a  : bit_b;
        obyv  = (i == 0) ? byv_a  : byv_b;
        obyte = (i == 0) ? byte_a : byte_b;
        cons = k - int'(lat[i]) + 1;
        ebv  = (cons > 0) && (cons % int'(dec[i]) == 0);
        ebyv = pend[i];
        pend[i] = 1'b0;
        chk("R3 bit_valid", i, k, {7'd0, obv}, {7'd0, ebv});
        if (ebv) begin
            ebit = 1'b0;
            for (int j = cons - int'(dec[i]); j < cons; j++) ebit ^= xs[i][j];
            chk("R1 R2 rnd_bit", i, k, {7'd0, obit}, {7'd0, ebit});
            if (nbits[i] == 0)
                chk("R4 first bit edge", i, k, 8'(k), 8'(dec[i] + lat[i] - 1));
            bits[i][nbits[i]] = ebit;
            nbits[i]++;
            last_bit[i] = ebit;
            if (nbits[i] % 8 == 0) begin
                pend[i] = 1'b1;
                for (int j = 0; j < 8; j++) pend_val[i][j] = bits[i][nbits[i] - 8 + j];
            end
        end else begin
            chk("R8 rnd_bit hold", i, k, {7'd0, obit}, {7'd0, last_bit[i]});
        end
        chk("R6 byte_valid", i, k, {7'd0, obyv}, {7'd0, ebyv});
        if (ebyv) last_byte[i] = pend_val[i];
        chk(ebyv ? "R6 rnd_byte" : "R8 rnd_byte hold", i, k, obyte, last_byte[i]);
    endtask

    task automatic run_phase(input int n, input int mode);
        for (int k = 0; k < n; k++) begin
            logic [2:0] v;
            if (mode == 0) v = 3'(k);
            else if (mode == 1) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                v = lfsr[2:0];
            end else v = 3'b111;
            jit = v;
            xs[0][k] = ^v;
            xs[1][k] = v[0];
            @(posedge clk);
            @(negedge clk);
            check_edge(0, k);
            check_edge(1, k);
        end
    endtask

    initial begin
        chk("R7 ratio rule A", 0, 0, 8'(gcd_tb(2 * MUL_A, DEC_A)), 8'd1);
        chk("R7 ratio rule B", 1, 0, 8'(gcd_tb(2 * MUL_B, DEC_B)), 8'd1);
        repeat (2) @(negedge clk);
        do_reset();
        run_phase(300, 0);
        do_reset();
        run_phase(400, 1);
        do_reset();
        run_phase(100, 2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule